// File: doc/BRIEF.md
# Masked Byte Sequence Match Detector

This block watches a stream of received bytes, each qualified by a valid strobe, for a programmable sequence of 1 to 64 bytes. Every pattern byte has its own 8-bit mask, so single bits can be excluded from the comparison. The block is armed by a register write. While it is armed, the first complete match raises a one-cycle `match_pulse`, which downstream logic uses to start a capture, a trigger, or both. The same cycle also drops `armed`, so each arming produces at most one pulse. Matching keeps a running record of every partial prefix match. A long stream that contains overlapping near-matches is therefore still detected.

A second, smaller comparator checks a 5-bit status bus against its own pattern and non-zero mask. The first status value that matches sets a sticky flag, and that value is held on `stat_val`. An arming write clears the flag, and so does any effective write to the status pattern or the status mask.

All configuration goes through one write port. The `wr_kind` encoding is: 0 pattern byte, 1 mask byte, 2 sequence length, 3 arm control, 4 status pattern, 5 status mask.

Top module: `seq_match_detector`

## Requirements
- R1: A write of kind 2 sets the sequence length to `wr_data`+1. The range is 1 to 64, and values above 63 clamp to 64. A match needs the last L valid bytes to equal pattern bytes 0..L-1 in arrival order. Pattern byte i is written with kind 0 and `wr_idx`=i.
- R2: Only bits where the byte's mask (kind 1, `wr_idx`=i) is 1 take part in the comparison against pattern byte i.
- R3: After reset every pattern mask is 0xFF, every pattern byte is 0x00, the length is 1, the status pattern is 0 and the status mask is 0x1F. `match_pulse`, `armed` and `stat_hit` are 0.
- R4: A kind 3 write with `wr_data[0]`=1 sets `armed`, and one with `wr_data[0]`=0 clears it. No `match_pulse` is produced while `armed` is 0.
- R5: A match pulse clears `armed` in the same cycle, so each arming yields at most one pulse.
- R6: Overlapping partial matches are tracked, so a sequence that begins inside an unfinished earlier attempt is still found.
- R7: Cycles with `byte_valid` low are ignored and do not advance the match window.
- R8: `match_pulse` is high in the single cycle that follows the clock edge at which the final matching byte is sampled.
- R9: `stat_hit` sets when `(stat_in ^ pattern) & mask` is zero. `stat_val` holds the value that set it, and later matches do not change that value.
- R10: A kind 3 write with `wr_data[0]`=1 clears `stat_hit`. If the status bus matches in that same cycle, the flag is set again instead and the new value is captured. A status pattern or mask write clears the flag without capturing.
- R11: A status mask write (kind 5) with a zero value is ignored entirely. It neither changes the mask nor clears the flag.
- R12: Any write of a pattern byte, mask byte or length discards all partial match progress, including the byte sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 3 | Write target (0 pat, 1 mask, 2 len, 3 arm, 4 stat pat, 5 stat mask) |
| wr_idx | input | 6 | Pattern byte index for kinds 0 and 1 |
| wr_data | input | 8 | Write value |
| byte_valid | input | 1 | Qualifies byte_in |
| byte_in | input | 8 | Received byte |
| stat_in | input | 5 | Status bus |
| match_pulse | output | 1 | One-cycle sequence match pulse |
| armed | output | 1 | Detector is armed |
| stat_hit | output | 1 | Sticky status match flag |
| stat_val | output | 5 | Status value that set the flag |

## Verification
Two events can fall in the same clock edge: an arming write, which clears the sticky status flag, and a status bus value that matches. The bench first sets the flag with one value. It then presents a second matching value and checks that `stat_val` keeps the first one. Next it issues the arming write while that second value is still on the bus, and it checks that the flag is set again with the second value captured rather than left cleared. The opposite case is an arming write while the bus does not match, and there the flag must read 0 afterwards.

// File: rtl/smd_pkg.sv
package smd_pkg;
  typedef enum logic [2:0] {
    WK_PAT  = 3'd0,
    WK_MSK  = 3'd1,
    WK_LEN  = 3'd2,
    WK_ARM  = 3'd3,
    WK_SPAT = 3'd4,
    WK_SMSK = 3'd5
  } wr_kind_e;
endpackage

// File: rtl/smd_cfg_regs.sv
module smd_cfg_regs #(
  parameter int MAX_LEN = 64,
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 5,
  parameter int IDX_W   = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [2:0]                     wr_kind,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [MAX_LEN-1:0][DATA_W-1:0] pat,
  output logic [MAX_LEN-1:0][DATA_W-1:0] msk,
  output logic [IDX_W-1:0]               len_m1,
  output logic [STAT_W-1:0]              stat_pat,
  output logic [STAT_W-1:0]              stat_msk,
  output logic                           arm_set,
  output logic                           arm_clr,
  output logic                           seq_chg,
  output logic                           stat_chg
);
  import smd_pkg::*;

  localparam logic [DATA_W-1:0] LEN_LIMIT = DATA_W'(MAX_LEN - 1);

  wr_kind_e kind;
  logic     idx_ok;
  logic     smsk_ok;

  assign kind     = wr_kind_e'(wr_kind);
  assign idx_ok   = (32'(wr_idx) < MAX_LEN);
  assign smsk_ok  = (wr_data[STAT_W-1:0] != '0);
  assign arm_set  = wr_en && (kind == WK_ARM) && wr_data[0];
  assign arm_clr  = wr_en && (kind == WK_ARM) && !wr_data[0];
  assign seq_chg  = wr_en && ((kind == WK_PAT) || (kind == WK_MSK) || (kind == WK_LEN));
  assign stat_chg = wr_en && ((kind == WK_SPAT) || ((kind == WK_SMSK) && smsk_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      pat      <= '0;
      msk      <= '1;
      len_m1   <= '0;
      stat_pat <= '0;
      stat_msk <= '1;
    end else if (wr_en) begin
      case (kind)
        WK_PAT:  if (idx_ok) pat[wr_idx] <= wr_data;
        WK_MSK:  if (idx_ok) msk[wr_idx] <= wr_data;
        WK_LEN:  len_m1 <= (wr_data > LEN_LIMIT) ? IDX_W'(MAX_LEN - 1) : wr_data[IDX_W-1:0];
        WK_SPAT: stat_pat <= wr_data[STAT_W-1:0];
        WK_SMSK: if (smsk_ok) stat_msk <= wr_data[STAT_W-1:0];
        default: ;
      endcase
    end
  end

  assert_stat_mask_nonzero_R11: assert property (@(posedge clk) disable iff (rst)
    stat_msk != '0);
  assert_len_in_range_R1: assert property (@(posedge clk) disable iff (rst)
    32'(len_m1) < MAX_LEN);
endmodule

// File: rtl/smd_seq_engine.sv
module smd_seq_engine #(
  parameter int MAX_LEN = 64,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           byte_valid,
  input  logic [DATA_W-1:0]              byte_in,
  input  logic [MAX_LEN-1:0][DATA_W-1:0] pat,
  input  logic [MAX_LEN-1:0][DATA_W-1:0] msk,
  input  logic [IDX_W-1:0]               len_m1,
  input  logic                           arm_set,
  input  logic                           arm_clr,
  input  logic                           seq_chg,
  output logic                           match_pulse,
  output logic                           armed
);
  logic [MAX_LEN-1:0] hit;
  logic [MAX_LEN-1:0] nxt;
  logic [MAX_LEN-1:0] part_q;
  logic               full;
  logic               fire;

  for (genvar k = 0; k < MAX_LEN; k++) begin : g_stage
    assign hit[k] = (((byte_in ^ pat[k]) & msk[k]) == '0);
    if (k == 0) begin : g_first
      assign nxt[k] = hit[k];
    end else begin : g_rest
      assign nxt[k] = part_q[k-1] & hit[k];
    end
  end

  assign full = nxt[len_m1];
  assign fire = byte_valid && !seq_chg && armed && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q      <= '0;
      match_pulse <= 1'b0;
      armed       <= 1'b0;
    end else begin
      match_pulse <= fire;
      if (seq_chg)         part_q <= '0;
      else if (byte_valid) part_q <= nxt;
      if (arm_set)         armed <= 1'b1;
      else if (arm_clr)    armed <= 1'b0;
      else if (fire)       armed <= 1'b0;
    end
  end

  assert_pulse_needs_arm_R4: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(armed));
  assert_one_shot_R5: assert property (@(posedge clk) disable iff (rst)
    (match_pulse && !$past(arm_set)) |-> !armed);
  assert_pulse_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    match_pulse |-> $past(byte_valid));
  assert_cfg_flush_R12: assert property (@(posedge clk) disable iff (rst)
    seq_chg |=> (part_q == '0));
endmodule

// File: rtl/smd_stat_match.sv
module smd_stat_match #(
  parameter int STAT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [STAT_W-1:0] stat_pat,
  input  logic [STAT_W-1:0] stat_msk,
  input  logic              clr_arm,
  input  logic              clr_cfg,
  output logic              stat_hit,
  output logic [STAT_W-1:0] stat_val
);
  logic cmp;

  assign cmp = (((stat_in ^ stat_pat) & stat_msk) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_hit <= 1'b0;
      stat_val <= '0;
    end else if (clr_cfg) begin
      stat_hit <= 1'b0;
    end else if (cmp && (clr_arm || !stat_hit)) begin
      stat_hit <= 1'b1;
      stat_val <= stat_in;
    end else if (clr_arm) begin
      stat_hit <= 1'b0;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_hit && !clr_arm && !clr_cfg) |=> stat_hit);
  assert_value_held_R9: assert property (@(posedge clk) disable iff (rst)
    (stat_hit && !clr_arm && !clr_cfg) |=> $stable(stat_val));
  assert_cfg_clears_R10: assert property (@(posedge clk) disable iff (rst)
    clr_cfg |=> !stat_hit);
  assert_captured_matches_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_hit) |-> (((stat_val ^ stat_pat) & stat_msk) == '0));
endmodule

// File: rtl/seq_match_detector.sv
module seq_match_detector #(
  parameter int MAX_LEN = 64,
  parameter int DATA_W  = 8,
  parameter int STAT_W  = 5,
  parameter int IDX_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic              match_pulse,
  output logic              armed,
  output logic              stat_hit,
  output logic [STAT_W-1:0] stat_val
);
  logic [MAX_LEN-1:0][DATA_W-1:0] pat;
  logic [MAX_LEN-1:0][DATA_W-1:0] msk;
  logic [IDX_W-1:0]               len_m1;
  logic [STAT_W-1:0]              stat_pat;
  logic [STAT_W-1:0]              stat_msk;
  logic                           arm_set;
  logic                           arm_clr;
  logic                           seq_chg;
  logic                           stat_chg;

  smd_cfg_regs #(.MAX_LEN(MAX_LEN), .DATA_W(DATA_W), .STAT_W(STAT_W), .IDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .pat(pat), .msk(msk), .len_m1(len_m1),
    .stat_pat(stat_pat), .stat_msk(stat_msk), .arm_set(arm_set),
    .arm_clr(arm_clr), .seq_chg(seq_chg), .stat_chg(stat_chg)
  );

  smd_seq_engine #(.MAX_LEN(MAX_LEN), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_in(byte_in),
    .pat(pat), .msk(msk), .len_m1(len_m1), .arm_set(arm_set),
    .arm_clr(arm_clr), .seq_chg(seq_chg), .match_pulse(match_pulse),
    .armed(armed)
  );

  smd_stat_match #(.STAT_W(STAT_W)) u_stat (
    .clk(clk), .rst(rst), .stat_in(stat_in), .stat_pat(stat_pat),
    .stat_msk(stat_msk), .clr_arm(arm_set), .clr_cfg(stat_chg),
    .stat_hit(stat_hit), .stat_val(stat_val)
  );
endmodule

// File: tb/test_seq_match_detector.sv
module test_seq_match_detector;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_kind = '0;
  logic [5:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_in = '0;
  logic [4:0] stat_in = 5'h1F;
  logic       match_pulse, armed, stat_hit;
  logic [4:0] stat_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  logic [7:0] m_pat [64];
  logic [7:0] m_msk [64];
  int         m_len;
  bit         m_armed;
  logic [7:0] hist[$];

  always #5 clk = ~clk;

  seq_match_detector i_seq_match_detector (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .byte_valid(byte_valid), .byte_in(byte_in),
    .stat_in(stat_in), .match_pulse(match_pulse), .armed(armed),
    .stat_hit(stat_hit), .stat_val(stat_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares match_pulse against the scoreboard every cycle
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      bit    e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, int'(match_pulse), int'(e));
    end
  end

  function automatic bit model_match();
    int n;
    n = hist.size();
    if (!m_armed || n < m_len) return 1'b0;
    for (int i = 0; i < m_len; i++)
      if (((hist[n - m_len + i] ^ m_pat[i]) & m_msk[i]) != 8'h00) return 1'b0;
    return 1'b1;
  endfunction

  task automatic put(input bit v, input logic [7:0] b, input string tag);
    bit e;
    @(negedge clk);
    byte_valid = v;
    byte_in    = b;
    @(posedge clk);
    #1 byte_valid = 1'b0;
    e = 1'b0;
    if (v) begin
      hist.push_back(b);
      if (hist.size() > 64) void'(hist.pop_front());
      e = model_match();
      if (e) m_armed = 1'b0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] k, input logic [5:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = k; wr_idx = idx; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    case (k)
      3'd0: begin m_pat[idx] = d; hist.delete(); end
      3'd1: begin m_msk[idx] = d; hist.delete(); end
      3'd2: begin m_len = (d > 63) ? 64 : int'(d) + 1; hist.delete(); end
      3'd3: m_armed = d[0];
      default: ;
    endcase
    exp_q.push_back(1'b0);
    tag_q.push_back("R12 cfg cycle");
  endtask

  task automatic set_stat(input logic [4:0] s);
    @(negedge clk);
    stat_in = s;
    @(posedge clk);
    #1;
  endtask

  task automatic seq(input logic [7:0] b[], input string tag);
    foreach (b[i]) put(1'b1, b[i], tag);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin m_pat[i] = 8'h00; m_msk[i] = 8'hFF; end
    m_len = 1; m_armed = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R3 reset pulse", int'(match_pulse), 0);
    chk("R3 reset armed", int'(armed), 0);
    chk("R3 reset stat_hit", int'(stat_hit), 0);
    @(negedge clk); rst = 1'b0;

    // R3: default length 1, pattern 0x00, full mask
    wr(3'd3, 0, 8'h01);
    @(negedge clk); chk("R4 armed after arm write", int'(armed), 1);
    put(1'b1, 8'h01, "R3 default no match");
    put(1'b1, 8'h00, "R3 default length-1 match");
    @(negedge clk); chk("R5 armed cleared", int'(armed), 0);

    // R1/R8: length 3
    wr(3'd0, 0, 8'hAA); wr(3'd0, 1, 8'hBB); wr(3'd0, 2, 8'hCC);
    wr(3'd2, 0, 8'd2);
    wr(3'd3, 0, 8'h01);
    seq('{8'hAA, 8'hBB, 8'hCC}, "R1 R8 three-byte match");
    seq('{8'hAA, 8'hBB, 8'hCC}, "R5 no second pulse");

    // R4: disarm blocks
    wr(3'd3, 0, 8'h01); wr(3'd3, 0, 8'h00);
    seq('{8'hAA, 8'hBB, 8'hCC}, "R4 disarmed no pulse");

    // R6: overlap, pattern 11 22 11 33
    wr(3'd0, 0, 8'h11); wr(3'd0, 1, 8'h22); wr(3'd0, 2, 8'h11); wr(3'd0, 3, 8'h33);
    wr(3'd2, 0, 8'd3);
    wr(3'd3, 0, 8'h01);
    seq('{8'h11, 8'h22, 8'h11, 8'h22, 8'h11, 8'h33}, "R6 overlapping match");

    // R7: invalid cycles ignored, even with disruptive data
    wr(3'd3, 0, 8'h01);
    put(1'b1, 8'h11, "R7 gap");
    put(1'b0, 8'h99, "R7 gap");
    put(1'b1, 8'h22, "R7 gap");
    put(1'b0, 8'h33, "R7 gap");
    put(1'b0, 8'h11, "R7 gap");
    put(1'b1, 8'h11, "R7 gap");
    put(1'b1, 8'h33, "R7 match across gaps");

    // R2: mask on byte 0
    wr(3'd1, 0, 8'h0F); wr(3'd0, 0, 8'h15); wr(3'd2, 0, 8'd0);
    wr(3'd3, 0, 8'h01);
    put(1'b1, 8'h16, "R2 unmasked bit differs");
    put(1'b1, 8'hA5, "R2 masked bits ignored");
    @(negedge clk); chk("R2 armed cleared after masked match", int'(armed), 0);
    wr(3'd1, 0, 8'hFF);

    // R12: cfg write mid-sequence discards progress
    wr(3'd0, 0, 8'hAA); wr(3'd0, 1, 8'hBB); wr(3'd0, 2, 8'hCC); wr(3'd2, 0, 8'd2);
    wr(3'd3, 0, 8'h01);
    seq('{8'hAA, 8'hBB}, "R12 prefix");
    wr(3'd1, 5, 8'hFF);
    put(1'b1, 8'hCC, "R12 progress discarded");
    @(negedge clk); chk("R12 still armed", int'(armed), 1);

    // R1: full 64-byte length, plus clamp
    for (int i = 0; i < 64; i++) wr(3'd0, 6'(i), 8'(i + 8'h40));
    wr(3'd2, 0, 8'd200);
    for (int i = 0; i < 63; i++) put(1'b1, 8'(i + 8'h40), "R1 64-byte prefix");
    put(1'b1, 8'h7F, "R1 64-byte match clamped length");

    // R9: status matcher
    wr(3'd4, 0, 8'h08); wr(3'd5, 0, 8'h18);
    set_stat(5'h10);
    @(negedge clk); chk("R9 no status match", int'(stat_hit), 0);
    set_stat(5'h0B);
    @(negedge clk); chk("R9 status hit", int'(stat_hit), 1);
    chk("R9 captured value", int'(stat_val), 'h0B);
    set_stat(5'h09);
    @(negedge clk); chk("R9 value sticky", int'(stat_val), 'h0B);

    // R10: arm and status match in the same cycle
    wr(3'd3, 0, 8'h01);
    @(negedge clk); chk("R10 same-cycle rehit flag", int'(stat_hit), 1);
    chk("R10 same-cycle new value", int'(stat_val), 'h09);
    set_stat(5'h10);
    wr(3'd3, 0, 8'h01);
    @(negedge clk); chk("R10 arm clears flag", int'(stat_hit), 0);
    set_stat(5'h0A);
    @(negedge clk); chk("R10 rehit", int'(stat_hit), 1);
    wr(3'd4, 0, 8'h0A);
    @(negedge clk); chk("R10 status pattern write clears", int'(stat_hit), 0);
    set_stat(5'h0A);
    @(negedge clk); chk("R10 hit after pattern write", int'(stat_hit), 1);

    // R11: zero status mask ignored (flag kept, mask kept)
    wr(3'd5, 0, 8'h00);
    @(negedge clk); chk("R11 zero mask no clear", int'(stat_hit), 1);
    set_stat(5'h1A);
    wr(3'd3, 0, 8'h01);
    @(negedge clk); chk("R11 mask unchanged no match", int'(stat_hit), 0);

    // R3: default status mask after reset
    @(negedge clk); rst = 1'b1; stat_in = 5'h1F;
    for (int i = 0; i < 64; i++) begin m_pat[i] = 8'h00; m_msk[i] = 8'hFF; end
    m_len = 1; m_armed = 1'b0; hist.delete();
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); chk("R3 default status no hit", int'(stat_hit), 0);
    set_stat(5'h00);
    @(negedge clk); chk("R3 default status pattern hit", int'(stat_hit), 1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule